// File: doc/BRIEF.md
# Multi-Pattern PRBS Word Checker

This block checks a stream of parallel words from a receive deserializer against one of five pseudo-random binary sequences. The sequence is chosen at run time. A second run-time input selects how a word is read. In NRZ form every bit is one sequence bit. In PAM4 form each adjacent bit pair is a Gray-coded four-level symbol that carries two sequence bits. Bit 0 of each word is the earliest bit in time. Every valid word advances the sequence by the full word width.

The checker finds its own alignment and needs no seed from outside. While it has no lock, it predicts each incoming bit from the bits received just before it. After a run of clean words it switches to its own free-running generator and reports lock. While locked it flags each word that has any mismatch, and it adds the mismatched bits to a saturating counter. A synchronous input clears that counter.

Top module: `prbs_word_checker`

## Requirements
- R1: After reset, `locked`, `word_err` and `err_count` are all zero.
- R2: `pat_sel` picks the sequence: 0 is x^7+x^6+1, 1 is x^9+x^5+1, 2 is x^11+x^9+1, 3 is x^13+x^12+x^2+x+1 and 4 is x^15+x^14+1 (5 to 7 act as 0). Word bit 0 is the earliest bit, and each valid word consumes W bits. A clean stream of the selected sequence gives no flags and no counts. A stream of a different sequence never gains lock.
- R3: While unlocked, the checker predicts each bit from previously received bits. It asserts `locked` after LOCK_WORDS (4) consecutive valid words with no mismatch, and never after fewer.
- R4: `word_err` is high for exactly the one clock after a valid word that was checked while locked and had at least one mismatched bit. It stays low for clean words and for words seen while unlocked.
- R5: For each valid word checked while locked, `err_count` increases by the number of mismatched bits in that word.
- R6: `err_count` saturates at all ones and does not wrap.
- R7: `cnt_clr` clears `err_count` on the next clock and takes priority over a count added in the same cycle.
- R8: Lock is lost after UNLOCK_WORDS (8) consecutive errored valid words. Seven are not enough.
- R9: A change of `pat_sel` or `pam4_mode` drops lock on the next clock. The word present in that cycle is ignored.
- R10: With `pam4_mode` high, bits 2k (MSB, earlier) and 2k+1 form a Gray symbol. It is decoded as 00 to 0, 01 to 1, 11 to 2 and 10 to 3, and the decoded bits are compared with the sequence. A flipped LSB of a symbol counts 1 error and a flipped MSB counts 2. W must be even.
- R11: Cycles with `din_valid` low do not advance the sequence, raise `word_err` or change `err_count`.
- R12: `en` low drops lock and ignores words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Checker enable |
| pat_sel | input | 3 | Sequence select |
| pam4_mode | input | 1 | 1: Gray-coded symbol pairs, 0: plain bits |
| din_valid | input | 1 | Word qualifier |
| din | input | W | Received word, bit 0 earliest |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| locked | output | 1 | Checker is aligned to the stream |
| word_err | output | 1 | Previous locked word had a mismatch |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
Clean streams are sent for all five sequences in NRZ form and for one in PAM4 form. These show that each polynomial and the bit order are right, and that lock is gained neither early nor late. A stream of the wrong sequence must never lock, which tells the polynomials apart. Words with one, three and twenty flipped bits separate the per-word flag from the bit count, and the twenty-bit word also drives a narrow-counter copy into saturation. In PAM4 form, flipping a symbol's MSB and then its LSB shows whether Gray decoding happens before the comparison. Runs of seven and eight errored words, valid gaps, an enable drop and select changes exercise how lock is held and lost.

// File: rtl/prbs_word_checker.sv
module prbs_word_checker #(
  parameter int W            = 32,
  parameter int CNT_W        = 32,
  parameter int LOCK_WORDS   = 4,
  parameter int UNLOCK_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       pat_sel,
  input  logic             pam4_mode,
  input  logic             din_valid,
  input  logic [W-1:0]     din,
  input  logic             cnt_clr,
  output logic             locked,
  output logic             word_err,
  output logic [CNT_W-1:0] err_count
);

  localparam int PCW = $clog2(W + 1);
  localparam int SW  = ((CNT_W > PCW) ? CNT_W : PCW) + 1;
  localparam int GW  = $clog2(LOCK_WORDS + 1);
  localparam int BW  = $clog2(UNLOCK_WORDS + 1);

  logic [14:0]    hist_q, hist_nx;
  logic [2:0]     sel_q;
  logic           mode_q;
  logic [GW-1:0]  good_q;
  logic [BW-1:0]  bad_q;
  logic [W-1:0]   gdec, rx, expw;
  logic [PCW-1:0] nerr;
  logic [SW-1:0]  sum;
  logic           sel_chg, take;

  function automatic logic pred(input logic [14:0] h, input logic [2:0] s);
    case (s)
      3'd1:    pred = h[8]  ^ h[4];
      3'd2:    pred = h[10] ^ h[8];
      3'd3:    pred = h[12] ^ h[11] ^ h[1] ^ h[0];
      3'd4:    pred = h[14] ^ h[13];
      default: pred = h[6]  ^ h[5];
    endcase
  endfunction

  for (genvar k = 0; k < W / 2; k++) begin : g_sym
    assign gdec[2*k]   = din[2*k];
    assign gdec[2*k+1] = din[2*k] ^ din[2*k+1];
  end

  assign rx      = pam4_mode ? gdec : din;
  assign sel_chg = (pat_sel != sel_q) || (pam4_mode != mode_q);
  assign take    = en && din_valid && !sel_chg;

  always_comb begin
    logic [14:0] h;
    h = hist_q;
    for (int i = 0; i < W; i++) begin
      expw[i] = pred(h, pat_sel);
      h = {h[13:0], locked ? expw[i] : rx[i]};
    end
    hist_nx = h;
  end

  always_comb begin
    nerr = '0;
    for (int i = 0; i < W; i++) nerr = nerr + PCW'(expw[i] ^ rx[i]);
  end

  assign sum = SW'(err_count) + SW'(nerr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q    <= '0;
      sel_q     <= '0;
      mode_q    <= 1'b0;
      good_q    <= '0;
      bad_q     <= '0;
      locked    <= 1'b0;
      word_err  <= 1'b0;
      err_count <= '0;
    end else begin
      sel_q    <= pat_sel;
      mode_q   <= pam4_mode;
      word_err <= 1'b0;

      if (cnt_clr)
        err_count <= '0;
      else if (take && locked && nerr != '0)
        err_count <= (sum > SW'({CNT_W{1'b1}})) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

      if (!en || sel_chg) begin
        locked <= 1'b0;
        good_q <= '0;
        bad_q  <= '0;
      end else if (take) begin
        hist_q <= hist_nx;
        if (locked) begin
          word_err <= (nerr != '0);
          if (nerr != '0) begin
            if (bad_q == BW'(UNLOCK_WORDS - 1)) begin
              locked <= 1'b0;
              bad_q  <= '0;
              good_q <= '0;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end else begin
            bad_q <= '0;
          end
        end else begin
          if (nerr == '0) begin
            if (good_q == GW'(LOCK_WORDS - 1)) begin
              locked <= 1'b1;
              good_q <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end else begin
            good_q <= '0;
          end
        end
      end
    end
  end

  // R4: a flag only follows a word that was taken while locked
  p_flag_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |-> $past(locked && en && din_valid));

  // R9: a select change costs the lock
  p_sel_change_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> !locked);

  // R7: clear empties the counter
  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_count == '0);

  // R6: the counter never falls except by clear
  p_count_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> err_count >= $past(err_count));

  // R11: idle cycles leave the counter and flag alone
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && din_valid) && !cnt_clr) |=> ($stable(err_count) && !word_err));

  // R12: disable clears the lock
  p_disable_unlocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);

  // R3: lock is only gained on a taken word
  p_lock_on_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(en && din_valid));

endmodule

// File: tb/prbs_word_checker_bench.sv
`timescale 1ns/1ps
module prbs_word_checker_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n, en, pam4_mode, din_valid, cnt_clr;
  logic [2:0] pat_sel;
  logic [W-1:0] din;
  logic locked, word_err, s_locked, s_word_err;
  logic [31:0] err_count;
  logic [3:0] s_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [14:0] bh;

  always #10 clk = ~clk;

  prbs_word_checker #(.W(W), .CNT_W(32)) u_prbs_word_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .pat_sel(pat_sel), .pam4_mode(pam4_mode),
    .din_valid(din_valid), .din(din), .cnt_clr(cnt_clr),
    .locked(locked), .word_err(word_err), .err_count(err_count));

  prbs_word_checker #(.W(W), .CNT_W(4)) u_prbs_word_checker_sat (
    .clk(clk), .rst_n(rst_n), .en(en), .pat_sel(pat_sel), .pam4_mode(pam4_mode),
    .din_valid(din_valid), .din(din), .cnt_clr(cnt_clr),
    .locked(s_locked), .word_err(s_word_err), .err_count(s_count));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic seq_bit(input logic [14:0] h, input int s);
    case (s)
      1:       return h[8] ^ h[4];
      2:       return h[10] ^ h[8];
      3:       return h[12] ^ h[11] ^ h[1] ^ h[0];
      4:       return h[14] ^ h[13];
      default: return h[6] ^ h[5];
    endcase
  endfunction

  task automatic make_word(input int s, input bit pam, output logic [W-1:0] w);
    for (int k = 0; k < W / 2; k++) begin
      logic b0, b1;
      b0 = seq_bit(bh, s); bh = {bh[13:0], b0};
      b1 = seq_bit(bh, s); bh = {bh[13:0], b1};
      w[2*k]   = b0;
      w[2*k+1] = pam ? (b0 ^ b1) : b1;
    end
  endtask

  task automatic put(input logic [W-1:0] w, input logic v);
    @(negedge clk);
    din = w; din_valid = v;
    @(posedge clk);
    #5;
  endtask

  task automatic send(input int s, input bit pam, input logic [W-1:0] flip);
    logic [W-1:0] w;
    make_word(s, pam, w);
    put(w ^ flip, 1'b1);
  endtask

  task automatic clear_count();
    @(negedge clk);
    din_valid = 1'b0; cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  task automatic lock_up(input int s, input bit pam);
    @(negedge clk);
    din_valid = 1'b0; pat_sel = 3'(s); pam4_mode = pam;
    clear_count();
    bh = 15'h7fff;
    for (int i = 0; i < 3; i++) send(s, pam, '0);
    check("R3 no lock after 3 words", locked, 0);
    for (int i = 0; i < 3; i++) send(s, pam, '0);
    check("R3 locked after 6 words", locked, 1);
  endtask

  task automatic t_reset();
    check("R1 locked after reset", locked, 0);
    check("R1 word_err after reset", word_err, 0);
    check("R1 err_count after reset", err_count, 0);
  endtask

  task automatic t_clean(input int s, input bit pam);
    int flags;
    flags = 0;
    lock_up(s, pam);
    for (int i = 0; i < 8; i++) begin
      send(s, pam, '0);
      flags += word_err;
    end
    check("R2 clean stream flags", flags, 0);
    check("R2 clean stream count", err_count, 0);
    check("R2 clean stream keeps lock", locked, 1);
  endtask

  task automatic t_wrong_seq();
    logic [W-1:0] w;
    @(negedge clk);
    din_valid = 1'b0; pat_sel = 3'd0; pam4_mode = 1'b0;
    bh = 15'h7fff;
    for (int i = 0; i < 12; i++) begin
      make_word(4, 1'b0, w);
      put(w, 1'b1);
    end
    check("R2 wrong sequence never locks", locked, 0);
  endtask

  task automatic t_errors();
    lock_up(0, 1'b0);
    send(0, 1'b0, 32'h0000_0001);
    check("R4 flag after errored word", word_err, 1);
    check("R5 count one flip", err_count, 1);
    send(0, 1'b0, '0);
    check("R4 flag clears on clean word", word_err, 0);
    send(0, 1'b0, 32'h8002_0008);
    check("R5 count three flips", err_count, 4);
    send(0, 1'b0, 32'h000F_FFFF);
    check("R5 count twenty flips", err_count, 24);
    check("R6 narrow counter saturates", s_count, 15);
    send(0, 1'b0, 32'h0000_0010);
    check("R6 narrow counter holds at max", s_count, 15);
    check("R5 count keeps adding", err_count, 25);
    @(negedge clk);
    cnt_clr = 1'b1;
    begin
      logic [W-1:0] w;
      make_word(0, 1'b0, w);
      din = w ^ 32'h0000_0003; din_valid = 1'b1;
    end
    @(negedge clk);
    cnt_clr = 1'b0; din_valid = 1'b0;
    check("R7 clear wins over add", err_count, 0);
    check("R7 narrow clear", s_count, 0);
  endtask

  task automatic t_gaps();
    logic [31:0] c0;
    lock_up(2, 1'b0);
    send(2, 1'b0, 32'h0000_0100);
    c0 = err_count;
    for (int i = 0; i < 5; i++) begin
      put(32'hDEAD_BEEF ^ 32'(i), 1'b0);
      check("R11 no flag on invalid", word_err, 0);
    end
    check("R11 count held over gap", err_count, c0);
    for (int i = 0; i < 3; i++) send(2, 1'b0, '0);
    check("R11 stream resumes clean", err_count, c0);
    check("R11 lock kept over gap", locked, 1);
    @(negedge clk);
    en = 1'b0; din_valid = 1'b1;
    @(posedge clk); #5;
    check("R12 enable low drops lock", locked, 0);
    check("R12 enable low word ignored", err_count, c0);
    @(negedge clk);
    en = 1'b1; din_valid = 1'b0;
  endtask

  task automatic t_unlock();
    lock_up(3, 1'b0);
    for (int i = 0; i < 7; i++) send(3, 1'b0, 32'h0000_0400);
    check("R8 lock kept after 7 bad", locked, 1);
    check("R8 count after 7 bad", err_count, 7);
    send(3, 1'b0, 32'h0000_0400);
    check("R8 lock lost after 8 bad", locked, 0);
    check("R8 count after 8 bad", err_count, 8);
    send(3, 1'b0, 32'h0F00_0000);
    check("R4 no flag while unlocked", word_err, 0);
    check("R5 no count while unlocked", err_count, 8);
  endtask

  task automatic t_sel_change();
    lock_up(2, 1'b0);
    @(negedge clk);
    din_valid = 1'b0; pat_sel = 3'd3;
    @(posedge clk); #5;
    check("R9 pattern change drops lock", locked, 0);
    lock_up(3, 1'b0);
    @(negedge clk);
    din_valid = 1'b1; din = 32'hFFFF_0000; pam4_mode = 1'b1;
    @(posedge clk); #5;
    check("R9 mode change drops lock", locked, 0);
    check("R9 word in change cycle ignored", err_count, 0);
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic t_pam4();
    lock_up(1, 1'b1);
    send(1, 1'b1, 32'h0000_0002);
    check("R10 symbol LSB flip counts 1", err_count, 1);
    check("R4 flag in PAM4", word_err, 1);
    send(1, 1'b1, 32'h0000_0004);
    check("R10 symbol MSB flip counts 2", err_count, 3);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; pat_sel = 3'd0; pam4_mode = 1'b0;
    din_valid = 1'b0; din = '0; cnt_clr = 1'b0; bh = 15'h7fff;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    t_reset();
    for (int s = 0; s < 5; s++) t_clean(s, 1'b0);
    t_clean(1, 1'b1);
    t_wrong_seq();
    t_errors();
    t_gaps();
    t_unlock();
    t_sel_change();
    t_pam4();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule